// File: doc/BRIEF.md
# Manchester Burst Clock and Data Recoverer

This block pulls a bit stream and a bit-rate timing reference out of a Manchester-coded serial line without any phase-locked loop. It is meant for short bursts that carry almost no preamble. A sampling clock running at `OVS` times the bit rate drives the whole block. The line passes through a two-stage synchroniser. A one-cycle edge flag comes from comparing the synchronised level with its value one cycle earlier.

When no timing window is open, an edge opens a counter window that lasts about three quarters of a bit period. Edges that arrive while the window is open are discarded. The level of the line when the window closes becomes the next decoded bit. That level is the first-half level of the following cell. Because only edges in an idle window can restart the timer, the block stays aligned to mid-cell transitions. The first transition of a burst is enough to lock it.

The line idles low. Each burst opens with a 0 bit, which is sent low then high. Its rising mid-cell edge is the first transition, and that bit serves only for alignment. Decoded bits leave on a valid/ready stream. `out_valid` stays high with `out_bit` unchanged until a cycle with `out_ready` high accepts the bit. If a new bit is decoded before the held one is taken, the new bit replaces it. The consumer must therefore accept each bit within one bit period. `locked` is a plain status output.

Top module: `mcr_top`

## Requirements
- R1: After reset, `out_valid` and `locked` are 0.
- R2: A line transition seen with no window open raises `locked` at the 3rd rising clock edge after the transition and raises `out_valid` at edge `OS_LEN+3`. `OS_LEN` is the integer nearest 0.75·`OVS` (12 for `OVS`=16). The 2-flop synchroniser, the edge compare and the window load account for this latency.
- R3: Transitions that occur while the window is open neither restart nor shorten it. A glitch inside the window leaves the decoded stream unchanged.
- R4: Each decoded bit equals the synchronised line level in the last cycle of the window. Coding is 0 = low-then-high and 1 = high-then-low. For a burst b0..bK-1 with b0=0, the stream is b1..bK-1 followed by one 0, which is the idle-low level sampled after the final cell.
- R5: `locked` rises when a transition opens a window. It falls exactly `TO_LEN` cycles after the last `out_valid` rise if no transition has arrived in that time. `TO_LEN` is the integer nearest 1.5·`OVS` (24 for `OVS`=16). Valid strobes occur only while locked.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_bit` stays stable until a new bit is decoded. A newly decoded bit replaces an unaccepted one. A cycle with `out_ready` high clears `out_valid` unless a new bit arrives in that same cycle.
- R7: Random bursts are decoded bit-exact when each bit is accepted within one bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, `OVS` times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous Manchester line, idles low |
| out_valid | output | 1 | Decoded bit available |
| out_ready | input | 1 | Consumer accepts the bit on this cycle |
| out_bit | output | 1 | Decoded bit value |
| locked | output | 1 | Block aligned to the current burst |

## Verification
A transition on `rx_line` reaches `locked` after three rising edges and reaches `out_valid` after `OS_LEN+3` edges. The directed latency test counts edges from a change driven at a falling edge and samples at falling edges on both sides of each due edge. Each decoded bit is due one bit period after the previous one. The monitor records a bit at the falling edge before the rising edge that accepts it. The fall of `locked` is measured in whole cycles from the last `out_valid` rise and must equal `TO_LEN`.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  // nearest integer of 0.75*n
  function automatic int win_len(input int n);
    return (3 * n + 2) / 4;
  endfunction
  // nearest integer of 1.5*n
  function automatic int tmo_len(input int n);
    return (3 * n + 1) / 2;
  endfunction
endpackage

// File: rtl/mcr_sync.sv
module mcr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic edge_seen
);
  logic [STAGES-1:0] chain;
  logic              last_lvl;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_lvl <= 1'b0;
    else        last_lvl <= chain[STAGES-1];

  assign lvl       = chain[STAGES-1];
  assign edge_seen = chain[STAGES-1] ^ last_lvl;
endmodule

// File: rtl/mcr_oneshot.sv
module mcr_oneshot #(
  parameter int WIN = 12,
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  output logic arm,
  output logic fire,
  output logic idle
);
  logic [CW-1:0] cnt;

  assign idle = (cnt == '0);
  assign arm  = idle & edge_seen;
  assign fire = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (arm)  cnt <= CW'(WIN);
    else if (!idle) cnt <= cnt - CW'(1);

  AST_OS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) && edge_seen |=> cnt == CW'(WIN)); // R2
  AST_OS_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && edge_seen |=> cnt == $past(cnt) - CW'(1)); // R3
endmodule

// File: rtl/mcr_lock.sv
module mcr_lock #(
  parameter int TMO = 24,
  localparam int TW = $clog2(TMO + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic idle,
  output logic locked
);
  logic [TW-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      locked <= 1'b0;
      quiet  <= '0;
    end else if (arm) begin
      locked <= 1'b1;
      quiet  <= '0;
    end else if (locked && idle) begin
      if (quiet == TW'(TMO - 1)) begin
        locked <= 1'b0;
        quiet  <= '0;
      end else begin
        quiet <= quiet + TW'(1);
      end
    end else begin
      quiet <= '0;
    end

  AST_LOCK_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> locked); // R5
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(idle)); // R5
endmodule

// File: rtl/mcr_outreg.sv
module mcr_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic lvl,
  input  logic ready,
  output logic valid,
  output logic data
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= 1'b0;
    end else if (fire) begin
      valid <= 1'b1;
      data  <= lvl;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end

  AST_FIRE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> valid && (data == $past(lvl))); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready && !fire |=> valid && $stable(data)); // R6
endmodule

// File: rtl/mcr_top.sv
module mcr_top #(
  parameter int OVS = 16,
  localparam int WIN = mcr_pkg::win_len(OVS),
  localparam int TMO = mcr_pkg::tmo_len(OVS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic locked
);
  logic lvl, edge_seen, arm, fire, idle;

  mcr_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line),
    .lvl(lvl), .edge_seen(edge_seen));

  mcr_oneshot #(.WIN(WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .edge_seen(edge_seen),
    .arm(arm), .fire(fire), .idle(idle));

  mcr_lock #(.TMO(TMO)) u_lock (
    .clk(clk), .rst_n(rst_n), .arm(arm), .idle(idle), .locked(locked));

  mcr_outreg u_out (
    .clk(clk), .rst_n(rst_n), .fire(fire), .lvl(lvl), .ready(out_ready),
    .valid(out_valid), .data(out_bit));

  AST_FIRE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> locked); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !locked); // R1
endmodule

// File: tb/mcr_top_test.sv
module mcr_top_test;
  localparam int N    = 16;
  localparam int HALF = N / 2;
  localparam int WIN  = 12;
  localparam int TMO  = 24;

  logic clk = 0, rst_n = 0, rx_line = 0, out_ready = 0;
  logic out_valid, out_bit, locked;
  int n_cmp = 0, n_bad = 0;
  int rdy_mode = 0;
  bit mon_en = 0, tmo_en = 0, done = 0;
  int got[256];
  int n_got = 0;
  int burst[64];
  int blen = 0;
  int since = 0;
  logic prev_valid = 0, prev_locked = 0;

  always #4 clk = ~clk;

  mcr_top #(.OVS(N)) uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .locked(locked));

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected decoded bit k of the current burst (R4)
  function automatic int exp_bit(input int k);
    if (k + 1 < blen) return burst[k + 1];
    return 0;
  endfunction

  // ready driver
  initial begin
    int gap = 0;
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0: out_ready = 0;
        1: out_ready = 1;
        default: begin
          if (gap >= 6) begin out_ready = 1; gap = 0; end
          else begin
            out_ready = $urandom % 3 == 0;
            gap = out_ready ? 0 : gap + 1;
          end
        end
      endcase
    end
  end

  // monitor: accepted bits and lock timeout (R5)
  always @(negedge clk) begin
    if (mon_en && out_valid && out_ready && n_got < 256) begin
      got[n_got] = out_bit;
      n_got++;
    end
    if (out_valid && !prev_valid) since = 0;
    else since++;
    if (tmo_en && prev_locked && !locked)
      check("R5 lock timeout cycles", since, TMO);
    prev_valid  = out_valid;
    prev_locked = locked;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_burst(input int glitch_cell);
    for (int c = 0; c < blen; c++) begin
      rx_line = burst[c][0];
      cycles(HALF);
      rx_line = ~burst[c][0];
      if (c == glitch_cell) begin
        cycles(2);
        rx_line = burst[c][0];
        cycles(2);
        rx_line = ~burst[c][0];
        cycles(HALF - 4);
      end else cycles(HALF);
    end
    rx_line = 0;
  endtask

  task automatic run_and_compare(input string req, input int glitch_cell);
    n_got = 0;
    mon_en = 1;
    send_burst(glitch_cell);
    cycles(3 * N);
    mon_en = 0;
    check({req, " bit count"}, n_got, blen);
    for (int k = 0; k < n_got && k < blen; k++)
      check({req, " bit"}, got[k], exp_bit(k));
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    cycles(3);
    check("R1 valid after reset", out_valid, 0);
    check("R1 locked after reset", locked, 0);
    rst_n = 1;
    cycles(5);
    check("R1 valid idle", out_valid, 0);

    // R2 latency: rising edge with ready low
    rdy_mode = 0;
    rx_line = 1;
    for (int k = 1; k <= WIN + 4; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 2) check("R2 locked before edge 3", locked, 0);
      if (k == 3) check("R2 locked at edge 3", locked, 1);
      if (k == WIN + 2) check("R2 valid before due edge", out_valid, 0);
      if (k == WIN + 3) begin
        check("R2 valid at due edge", out_valid, 1);
        check("R4 sampled high level", out_bit, 1);
      end
    end
    cycles(60);
    rx_line = 0;
    cycles(80);
    rdy_mode = 1;
    cycles(3);
    check("R6 ready clears valid", out_valid, 0);

    // R6 replace while not accepted: burst 0,1,1 -> 1,1,0 ; held = 0
    rdy_mode = 0;
    cycles(3);
    blen = 3; burst[0] = 0; burst[1] = 1; burst[2] = 1;
    send_burst(-1);
    cycles(3 * N);
    check("R6 valid held", out_valid, 1);
    check("R6 newest bit held", out_bit, 0);
    cycles(20);
    check("R6 bit stable", out_bit, 0);
    rdy_mode = 1;
    cycles(3);
    check("R6 accepted", out_valid, 0);

    // R4 directed pattern with ready high, R5 timeout measured
    tmo_en = 1;
    blen = 6; burst[0] = 0; burst[1] = 0; burst[2] = 1; burst[3] = 0; burst[4] = 1; burst[5] = 1;
    run_and_compare("R4 directed", -1);
    check("R5 unlocked after idle", locked, 0);

    // R3 glitch inside window
    blen = 6; burst[0] = 0; burst[1] = 1; burst[2] = 0; burst[3] = 0; burst[4] = 1; burst[5] = 0;
    run_and_compare("R3 glitch", 2);

    // R7 random bursts, random ready
    rdy_mode = 2;
    for (int b = 0; b < 20; b++) begin
      blen = 8 + int'($urandom % 17);
      burst[0] = 0;
      for (int i = 1; i < blen; i++) burst[i] = int'($urandom % 2);
      run_and_compare("R7 random", -1);
      check("R5 unlocked between bursts", locked, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule